// File: doc/BRIEF.md
# Power Domain Gating Sequencer

The sequencer switches a set of power partitions off and on in a fixed, safe order. For each partition it drives a module reset, a module clock enable, a one-cycle power-switch toggle request, and an isolation-clamp release command. It watches one power status bit per partition. The analog switch is outside the block: status flips some cycles after a toggle. The clamp logic is also outside: it reports busy until a release command has taken effect.

A host issues single requests with a partition index and an on/off flag. The handshake is valid/ready and ends with a one-cycle done pulse. Two further strobes act on groups of partitions. Suspend turns off every force-gated partition that is currently on and remembers which ones it turned off. Resume turns exactly those partitions back on. Only one operation runs at a time. While an operation runs, busy is high and ready is low.

Top module: `pgs_gate_seq`

## Requirements
- R1: A request whose target status bit already equals the requested state ends with one done pulse and changes no reset, clock, toggle or clamp output.
- R2: Every real transition sets the partition's reset bit before its toggle pulse is issued.
- R3: A transition issues one single-cycle toggle pulse that carries the partition index. The sequencer then waits for the status bit to reach the requested state. A power-off ends at that point, with reset left asserted and the clock off.
- R4: A power-on then runs these steps in order:
  - it sets the clock enable;
  - it waits at least RST_DLY cycles, then issues the clamp command;
  - it waits until clamp busy is low, then clears the clock enable;
  - it then releases reset.
- R5: The clamp mask is one-hot at bit p for partition p. The exceptions are partitions SWAP_A and SWAP_B, which each use the other's bit. With the defaults, partition 1 uses bit 2 and partition 2 uses bit 1.
- R6: A suspend strobe powers off each partition whose FORCE_MASK bit is set and whose status is on, in index order, and marks it. It clears the mark of every other partition.
- R7: A resume strobe powers on only the marked partitions, in index order.
- R8: A request with an index of N_PART or above, or for a partition whose RUNTIME_MASK bit is clear, gives one done pulse and has no other effect.
- R9: If the status bit has not changed TIMEOUT cycles after the toggle, err_o rises. The step then ends with reset held asserted. err_o clears when the next operation is accepted.
- R10: req_ready_o is high only while the block is idle and neither strobe is high. A suspend or resume strobe wins over a simultaneous request, which is then not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Single-partition request valid |
| req_ready_o | output | 1 | Request accepted this cycle when high together with valid |
| req_part_i | input | IDX_W | Requested partition index |
| req_on_i | input | 1 | 1 = power on, 0 = power off |
| suspend_i | input | 1 | Suspend strobe, taken when idle |
| resume_i | input | 1 | Resume strobe, taken when idle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse at the end of an operation |
| err_o | output | 1 | Status-wait timeout seen in the current operation |
| pwr_status_i | input | N_PART | Per-partition power status, 1 = on |
| toggle_valid_o | output | 1 | Power-switch toggle request pulse |
| toggle_part_o | output | IDX_W | Partition index for the toggle |
| clamp_valid_o | output | 1 | Clamp-release command pulse |
| clamp_mask_o | output | N_PART | One-hot clamp-release mask |
| clamp_busy_i | input | 1 | Clamp release still pending |
| part_rst_o | output | N_PART | Per-partition module reset |
| part_clk_en_o | output | N_PART | Per-partition module clock enable |

## Verification
The bench repeats a request for a partition that is already on. A design that skipped the status check would toggle the switch off again instead of only pulsing done. Power-on requests for the swapped pair are checked against the clamp mask. A design that used the plain index would release the wrong partition's isolation. The bench checks the settle gap between clock enable and clamp command, and it issues a suspend with one force-gated partition already off and one partition that is not force-gated. A design that marked the wrong set would gate or revive the wrong partitions at resume. A dead switch exercises the timeout, including that reset stays held and that err_o clears on the next request. A request held during busy, and a request raised together with a suspend strobe, show whether a design lets a second operation in.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_TOGGLE, S_WAIT_PWR, S_CLK_ON, S_SETTLE, S_CLAMP,
    S_WAIT_CLAMP, S_RST_OFF, S_STEP, S_DONE, S_SUSPEND, S_RESUME
  } seq_state_e;

  typedef enum logic [1:0] {M_SINGLE, M_SUSPEND, M_RESUME} seq_mode_e;
endpackage

// File: rtl/pgs_timer.sv
module pgs_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pgs_clamp_map.sv
module pgs_clamp_map #(
  parameter int N_PART = 5,
  parameter int IDX_W  = 3,
  parameter int SWAP_A = 1,
  parameter int SWAP_B = 2
) (
  input  logic [IDX_W-1:0]  part_i,
  output logic [N_PART-1:0] mask_o
);
  // bit b is driven by the partition that owns it after the pair swap
  for (genvar b = 0; b < N_PART; b++) begin : g_bit
    localparam int SRC = (b == SWAP_A) ? SWAP_B : (b == SWAP_B) ? SWAP_A : b;
    assign mask_o[b] = (part_i == IDX_W'(SRC));
  end
endmodule

// File: rtl/pgs_gate_seq.sv
module pgs_gate_seq
  import pgs_pkg::*;
#(
  parameter int                N_PART       = 5,
  parameter int                RST_DLY      = 16,
  parameter int                TIMEOUT      = 255,
  parameter logic [N_PART-1:0] RUNTIME_MASK = 5'b01011,
  parameter logic [N_PART-1:0] FORCE_MASK   = 5'b00111,
  parameter int                SWAP_A       = 1,
  parameter int                SWAP_B       = 2,
  localparam int               IDX_W        = (N_PART > 1) ? $clog2(N_PART) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [IDX_W-1:0]  req_part_i,
  input  logic              req_on_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  input  logic [N_PART-1:0] pwr_status_i,
  output logic              toggle_valid_o,
  output logic [IDX_W-1:0]  toggle_part_o,
  output logic              clamp_valid_o,
  output logic [N_PART-1:0] clamp_mask_o,
  input  logic              clamp_busy_i,
  output logic [N_PART-1:0] part_rst_o,
  output logic [N_PART-1:0] part_clk_en_o
);
  localparam int CNT_W   = $clog2(N_PART + 1);
  localparam int EXT     = 2 ** IDX_W;
  localparam int TMR_MAX = (RST_DLY > TIMEOUT) ? RST_DLY : TIMEOUT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  seq_state_e        state_q;
  seq_mode_e         mode_q;
  logic [IDX_W-1:0]  part_q;
  logic              on_q;
  logic [CNT_W-1:0]  idx_q;
  logic [N_PART-1:0] mark_q, rst_q, clk_q;
  logic              err_q;
  logic [EXT-1:0]    rt_ext;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              idle, at_end, pwr_ok;
  logic [IDX_W-1:0]  idx_part;

  assign rt_ext   = EXT'(RUNTIME_MASK);
  assign idle     = (state_q == S_IDLE);
  assign at_end   = (idx_q == CNT_W'(N_PART));
  assign idx_part = IDX_W'(idx_q);
  assign pwr_ok   = (pwr_status_i[part_q] == on_q);
  assign tmr_load = (state_q == S_TOGGLE) || (state_q == S_CLK_ON);
  assign tmr_val  = (state_q == S_TOGGLE) ? TMR_W'(TIMEOUT) : TMR_W'(RST_DLY);

  pgs_timer #(.W(TMR_W)) i_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  pgs_clamp_map #(.N_PART(N_PART), .IDX_W(IDX_W), .SWAP_A(SWAP_A), .SWAP_B(SWAP_B))
    i_clamp_map (.part_i(part_q), .mask_o(clamp_mask_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mode_q  <= M_SINGLE;
      part_q  <= '0;
      on_q    <= 1'b0;
      idx_q   <= '0;
      mark_q  <= '0;
      rst_q   <= '0;
      clk_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (suspend_i) begin
            err_q <= 1'b0; mode_q <= M_SUSPEND; idx_q <= '0; state_q <= S_SUSPEND;
          end else if (resume_i) begin
            err_q <= 1'b0; mode_q <= M_RESUME; idx_q <= '0; state_q <= S_RESUME;
          end else if (req_valid_i) begin
            err_q  <= 1'b0;
            mode_q <= M_SINGLE;
            if (rt_ext[req_part_i]) begin
              part_q  <= req_part_i;
              on_q    <= req_on_i;
              state_q <= S_CHECK;
            end else begin
              state_q <= S_DONE;   // unsupported index: no side effects
            end
          end
        end
        S_SUSPEND: begin
          if (at_end) state_q <= S_DONE;
          else if (FORCE_MASK[idx_part] && pwr_status_i[idx_part]) begin
            mark_q[idx_part] <= 1'b1;
            part_q  <= idx_part;
            on_q    <= 1'b0;
            state_q <= S_CHECK;
          end else begin
            mark_q[idx_part] <= 1'b0;
            idx_q <= idx_q + 1'b1;
          end
        end
        S_RESUME: begin
          if (at_end) state_q <= S_DONE;
          else if (mark_q[idx_part]) begin
            part_q  <= idx_part;
            on_q    <= 1'b1;
            state_q <= S_CHECK;
          end else idx_q <= idx_q + 1'b1;
        end
        S_CHECK: begin
          if (pwr_ok) state_q <= S_STEP;
          else begin
            rst_q[part_q] <= 1'b1;
            state_q <= S_TOGGLE;
          end
        end
        S_TOGGLE: state_q <= S_WAIT_PWR;
        S_WAIT_PWR: begin
          if (pwr_ok) begin
            if (on_q) begin
              clk_q[part_q] <= 1'b1;
              state_q <= S_CLK_ON;
            end else state_q <= S_STEP;
          end else if (tmr_zero) begin
            err_q   <= 1'b1;
            state_q <= S_STEP;
          end
        end
        S_CLK_ON:  state_q <= S_SETTLE;
        S_SETTLE:  if (tmr_zero) state_q <= S_CLAMP;
        S_CLAMP:   state_q <= S_WAIT_CLAMP;
        S_WAIT_CLAMP: begin
          if (!clamp_busy_i) begin
            clk_q[part_q] <= 1'b0;
            state_q <= S_RST_OFF;
          end
        end
        S_RST_OFF: begin
          rst_q[part_q] <= 1'b0;
          state_q <= S_STEP;
        end
        S_STEP: begin
          if (mode_q == M_SINGLE) state_q <= S_DONE;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= (mode_q == M_SUSPEND) ? S_SUSPEND : S_RESUME;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o    = idle && !suspend_i && !resume_i;
  assign busy_o         = !idle;
  assign done_o         = (state_q == S_DONE);
  assign err_o          = err_q;
  assign toggle_valid_o = (state_q == S_TOGGLE);
  assign toggle_part_o  = part_q;
  assign clamp_valid_o  = (state_q == S_CLAMP);
  assign part_rst_o     = rst_q;
  assign part_clk_en_o  = clk_q;

  p_rst_before_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_valid_o |-> part_rst_o[toggle_part_o]);
  p_toggle_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_valid_o |=> !toggle_valid_o);
  p_clk_under_rst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|part_clk_en_o) |-> ((part_clk_en_o & part_rst_o) == part_clk_en_o));
  p_clamp_with_clk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_valid_o |-> ((clamp_mask_o != '0) && $onehot0(part_clk_en_o) && (|part_clk_en_o)));
  p_clamp_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_valid_o |-> ($countones(clamp_mask_o) == 1));
  p_ready_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !busy_o);
  p_done_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/test_pgs_gate_seq.sv
module test_pgs_gate_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int RST_DLY = 5;
  localparam int TIMEOUT = 20;
  localparam int SW_LAT = 4;
  localparam int CL_LAT = 3;
  localparam logic [N-1:0] RT_M = 5'b01011;
  localparam logic [N-1:0] FC_M = 5'b00111;
  localparam int K_RSET = 1, K_RCLR = 2, K_CSET = 3, K_CCLR = 4, K_TGL = 5, K_CLMP = 6, K_DONE = 7;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_on_i = 1'b0, suspend_i = 1'b0, resume_i = 1'b0;
  logic [2:0] req_part_i = '0;
  logic req_ready_o, busy_o, done_o, err_o, toggle_valid_o, clamp_valid_o;
  logic [2:0] toggle_part_o;
  logic [N-1:0] clamp_mask_o, part_rst_o, part_clk_en_o;
  logic [N-1:0] pwr = 5'b00100;
  logic clamp_busy_i = 1'b0;

  int errors = 0, checks = 0, cyc = 0, clk_set_cyc = 0;
  int exp_q[$];
  string tag_q[$];
  logic mon_en = 1'b0, finished = 1'b0;
  logic [N-1:0] prev_rst, prev_clk, dead = '0;
  logic [N-1:0] mstat = 5'b00100, mrst = '0, mmark = '0;

  pgs_gate_seq #(.N_PART(N), .RST_DLY(RST_DLY), .TIMEOUT(TIMEOUT),
    .RUNTIME_MASK(RT_M), .FORCE_MASK(FC_M), .SWAP_A(1), .SWAP_B(2)) i_pgs_gate_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_part_i, .req_on_i,
    .suspend_i, .resume_i, .busy_o, .done_o, .err_o, .pwr_status_i(pwr),
    .toggle_valid_o, .toggle_part_o, .clamp_valid_o, .clamp_mask_o, .clamp_busy_i,
    .part_rst_o, .part_clk_en_o);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // environment: power switch and clamp
  int sw_cnt = 0, cl_cnt = 0, sw_part = 0;
  always @(posedge clk_i) begin
    if (toggle_valid_o && !dead[toggle_part_o]) begin
      sw_cnt <= SW_LAT; sw_part <= int'(toggle_part_o);
    end else if (sw_cnt != 0) begin
      sw_cnt <= sw_cnt - 1;
      if (sw_cnt == 1) pwr[sw_part] <= ~pwr[sw_part];
    end
    if (clamp_valid_o) begin
      clamp_busy_i <= 1'b1; cl_cnt <= CL_LAT;
    end else if (cl_cnt != 0) begin
      cl_cnt <= cl_cnt - 1;
      if (cl_cnt == 1) clamp_busy_i <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input int k, input int a, input string t);
    exp_q.push_back(k * 256 + a);
    tag_q.push_back(t);
  endtask

  function automatic int swp(input int p);
    return (p == 1) ? 2 : (p == 2) ? 1 : p;
  endfunction

  // behavioural reference: expected event list of one transition
  task automatic model_core(input int p, input bit on);
    if (mstat[p] == on) return;
    if (!mrst[p]) push(K_RSET, p, "R2");
    mrst[p] = 1'b1;
    push(K_TGL, p, "R3");
    if (dead[p]) return;
    mstat[p] = on;
    if (on) begin
      push(K_CSET, p, "R4");
      push(K_CLMP, 1 << swp(p), "R5");
      push(K_CCLR, p, "R4");
      push(K_RCLR, p, "R4");
      mrst[p] = 1'b0;
    end
  endtask

  task automatic got(input int k, input int a);
    string t;
    int e;
    if (k == K_CSET) clk_set_cyc = cyc;
    if (k == K_CLMP) chk(cyc - clk_set_cyc > RST_DLY, "R4", "settle gap", cyc - clk_set_cyc, RST_DLY + 1);
    if (exp_q.size() == 0) begin
      chk(1'b0, "R1", "unexpected event", k * 256 + a, 0);
      return;
    end
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    chk(e == k * 256 + a, t, "event", k * 256 + a, e);
  endtask

  always @(negedge clk_i) if (mon_en) begin
    cyc++;
    for (int i = 0; i < N; i++) begin
      if (part_rst_o[i] != prev_rst[i]) got(part_rst_o[i] ? K_RSET : K_RCLR, i);
      if (part_clk_en_o[i] != prev_clk[i]) got(part_clk_en_o[i] ? K_CSET : K_CCLR, i);
    end
    if (toggle_valid_o) got(K_TGL, int'(toggle_part_o));
    if (clamp_valid_o) got(K_CLMP, int'(clamp_mask_o));
    if (done_o) got(K_DONE, 0);
    prev_rst = part_rst_o;
    prev_clk = part_clk_en_o;
  end

  task automatic wait_idle();
    @(negedge clk_i);
    for (int i = 0; i < 3000; i++) begin
      if (exp_q.size() == 0 && !busy_o) break;
      @(negedge clk_i);
    end
    chk(exp_q.size() == 0, "R10", "pending events", exp_q.size(), 0);
  endtask

  task automatic request(input int p, input bit on, input string t);
    if (p < N && RT_M[p]) model_core(p, on);
    push(K_DONE, 0, t);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_part_i = 3'(p); req_on_i = on;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    wait_idle();
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk_i);
    if (!finished) begin
      chk(1'b0, "R10", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1'b1 && busy_o == 1'b0, "R10", "reset ready/busy", {req_ready_o, busy_o}, 2);
    chk(part_rst_o == '0, "R2", "reset part_rst", part_rst_o, 0);
    chk(part_clk_en_o == '0, "R4", "reset clk_en", part_clk_en_o, 0);
    chk(done_o == 1'b0 && err_o == 1'b0, "R9", "reset done/err", {done_o, err_o}, 0);
    rst_ni = 1'b1;
    prev_rst = '0; prev_clk = '0;
    mon_en = 1'b1;

    request(0, 1'b1, "R4");          // on, plain clamp bit
    request(0, 1'b1, "R1");          // already on: no side effects
    request(1, 1'b1, "R5");          // swapped clamp bit 2
    request(3, 1'b1, "R4");
    request(1, 1'b0, "R3");          // off ends after status change
    chk(part_rst_o[1] == 1'b1, "R3", "reset held after off", part_rst_o[1], 1);
    request(2, 1'b1, "R8");          // runtime gating disabled
    request(7, 1'b1, "R8");          // index out of range
    chk(pwr == 5'b01101, "R8", "status after ignored", pwr, 5'b01101);

    // suspend together with a request: strobe wins
    for (int i = 0; i < N; i++) begin
      mmark[i] = FC_M[i] && mstat[i];
      if (mmark[i]) model_core(i, 1'b0);
    end
    push(K_DONE, 0, "R6");
    @(negedge clk_i);
    suspend_i = 1'b1; req_valid_i = 1'b1; req_part_i = 3'd3; req_on_i = 1'b0;
    #1 chk(req_ready_o == 1'b0, "R10", "ready with strobe", req_ready_o, 0);
    @(negedge clk_i);
    suspend_i = 1'b0; req_valid_i = 1'b0;
    wait_idle();
    chk(pwr == 5'b01000, "R6", "status after suspend", pwr, 5'b01000);

    for (int i = 0; i < N; i++) if (mmark[i]) model_core(i, 1'b1);
    push(K_DONE, 0, "R7");
    @(negedge clk_i); resume_i = 1'b1;
    @(negedge clk_i); resume_i = 1'b0;
    wait_idle();
    chk(pwr == 5'b01101, "R7", "status after resume", pwr, 5'b01101);

    // dead switch: timeout
    dead[1] = 1'b1;
    request(1, 1'b1, "R9");
    chk(err_o == 1'b1, "R9", "err after timeout", err_o, 1);
    chk(part_rst_o[1] == 1'b1, "R9", "reset held on timeout", part_rst_o[1], 1);
    dead[1] = 1'b0;

    // request held while busy must not be taken
    model_core(1, 1'b1);
    push(K_DONE, 0, "R10");
    @(negedge clk_i);
    req_valid_i = 1'b1; req_part_i = 3'd1; req_on_i = 1'b1;
    @(negedge clk_i);
    req_part_i = 3'd0; req_on_i = 1'b0;
    chk(req_ready_o == 1'b0 && busy_o == 1'b1, "R10", "ready while busy", req_ready_o, 0);
    chk(err_o == 1'b0, "R9", "err cleared on accept", err_o, 0);
    repeat (3) @(negedge clk_i);
    req_valid_i = 1'b0;
    wait_idle();
    chk(pwr == 5'b01111, "R10", "final status", pwr, 5'b01111);
    chk(part_rst_o == '0 && part_clk_en_o == '0, "R4", "final rst/clk", {part_rst_o, part_clk_en_o}, 0);

    repeat (5) @(negedge clk_i);
    chk(exp_q.size() == 0, "R1", "stray events", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule